// File: doc/BRIEF.md
# UART Sleep and Wake-up Controller

This block decides when a group of UART channels may stop their shared oscillator. It runs from an always-on clock and watches each channel's idle qualifiers. When every channel is idle, it drops the oscillator enable and raises a sleep status flag. The qualifiers are the sleep-enable bit, the interrupt-pending flag, the two FIFO empty flags, the receive line level, a non-zero baud divisor and clear modem-status change bits.

While the oscillator is stopped, synchronising edge detectors on the receive lines and modem inputs keep watching for activity. A wake cause restarts the oscillator. The causes are sleep being disabled, a new interrupt, a transmit-holding write, or any pin toggle. A wake also sets a wake-up interrupt on every channel, whatever the channel's interrupt enables. The clocked logic is then held off by a programmable settle count. Once the wake-up interrupts are read and the qualifiers hold again, the controller goes back to sleep without software help.

Top module: `uart_sleep_ctrl`

## Requirements
- R1: During and right after reset, with sleep disabled, `osc_en` is 1, `sleep_flag` is 0 and `wake_irq` is all zeros.
- R2: When every channel qualifies, `osc_en` falls and `sleep_flag` rises at the next clock edge. A channel qualifies when it has `sleep_en`=1, `irq_pend`=0, both FIFO empty flags at 1, a non-zero divisor, its 4 `msr_delta` bits at 0, its `wake_irq` at 0 and no wake event in that cycle.
- R3: The receive-idle qualifier of a channel needs its synchronised `rx_pin` at 1 when `ir_mode`=0, and at 0 when `ir_mode`=1.
- R4: A single non-qualifying channel keeps all channels awake.
- R5: While asleep, `sleep_en`=0, `irq_pend`=1 or a `thr_wr` pulse on any channel sets `osc_en` to 1 at the next clock edge.
- R6: While asleep, a level change on any `rx_pin` or `modem_in` bit sets `osc_en` to 1 on the third clock edge after the change: two synchroniser stages, then the edge compare.
- R7: On the edge where `osc_en` rises after sleep, every `wake_irq` bit is set. A bit then stays set until an `isr_rd` pulse on its channel clears it at the following edge.
- R8: After `osc_en` rises, `sleep_flag` stays 1 for `settle_cfg`+1 clock edges and falls on the next one. `settle_cfg` is sampled at the wake edge.
- R9: After settling, the controller stays awake while any `wake_irq` bit is set. It re-enters sleep at the first edge after the qualifiers hold again.
- R10: While asleep, changes to the divisor, FIFO flags or modem-status change bits that are not wake events leave `osc_en` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_en | input | NCH | Sleep enable, one bit per channel |
| irq_pend | input | NCH | Channel interrupt pending |
| txf_empty | input | NCH | Transmit FIFO empty |
| rxf_empty | input | NCH | Receive FIFO empty |
| rx_pin | input | NCH | Asynchronous receive line |
| ir_mode | input | NCH | Infrared mode: idle receive level is low |
| divisor | input | NCH*DIV_W | Baud divisor of each channel |
| modem_in | input | NCH*MDM_W | Asynchronous modem input pins |
| msr_delta | input | NCH*MDM_W | Modem-status change bits |
| thr_wr | input | NCH | Transmit holding write strobe |
| isr_rd | input | NCH | Interrupt status read strobe |
| settle_cfg | input | SETTLE_W | Settle count loaded at wake |
| osc_en | output | 1 | Shared oscillator enable |
| sleep_flag | output | 1 | Asleep or settling |
| wake_irq | output | NCH | Wake-up interrupt per channel |

## Verification
The assertions assume several things about the inputs. Strobes like `thr_wr` and `isr_rd` arrive synchronous to the always-on clock. Only the receive and modem pins may change asynchronously. The FIFO and interrupt flags reflect a halted channel while the oscillator is off. The stimulus keeps within this by changing inputs only at the falling clock edge. It changes the receive and modem pins only in the directed cases. In the random phase it holds the pin levels fixed and varies only the qualifiers, the strobes and the settle count.

// File: rtl/uslp_pkg.sv
package uslp_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_SETTLE = 2'd2
  } pwr_state_t;
endpackage

// File: rtl/uslp_pin_watch.sv
// Multi-stage synchroniser with toggle detection on the always-on clock.
module uslp_pin_watch #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins,
  output logic [W-1:0] pins_s,
  output logic         toggled
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= pins;
  end

  genvar k;
  generate
    for (k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[k] <= RST_VAL;
        else     stg[k] <= stg[k-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= stg[STAGES-1];
  end

  assign pins_s  = stg[STAGES-1];
  assign toggled = |(stg[STAGES-1] ^ prev);
endmodule

// File: rtl/uslp_chan_qual.sv
// Per-channel sleep qualification and wake event detection.
module uslp_chan_qual #(
  parameter int DIV_W = 16,
  parameter int MDM_W = 4
) (
  input  logic             sleep_en,
  input  logic             irq_pend,
  input  logic             txf_empty,
  input  logic             rxf_empty,
  input  logic             rx_s,
  input  logic             ir_mode,
  input  logic [DIV_W-1:0] divisor,
  input  logic [MDM_W-1:0] msr_delta,
  input  logic             thr_wr,
  input  logic             pin_evt,
  input  logic             wake_pend,
  output logic             qual,
  output logic             wake_evt
);
  logic rx_idle;

  always_comb begin
    rx_idle  = rx_s ^ ir_mode;
    wake_evt = ~sleep_en | irq_pend | thr_wr | pin_evt;
    qual     = sleep_en & ~irq_pend & txf_empty & rxf_empty & rx_idle
             & (|divisor) & ~(|msr_delta) & ~wake_pend & ~wake_evt;
  end
endmodule

// File: rtl/uslp_settle.sv
// Down-counter holding off clocked logic after the oscillator restarts.
module uslp_settle #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (run && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/uart_sleep_ctrl.sv
module uart_sleep_ctrl #(
  parameter int NCH = 2,
  parameter int DIV_W = 16,
  parameter int MDM_W = 4,
  parameter int SETTLE_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        sleep_en,
  input  logic [NCH-1:0]        irq_pend,
  input  logic [NCH-1:0]        txf_empty,
  input  logic [NCH-1:0]        rxf_empty,
  input  logic [NCH-1:0]        rx_pin,
  input  logic [NCH-1:0]        ir_mode,
  input  logic [NCH*DIV_W-1:0]  divisor,
  input  logic [NCH*MDM_W-1:0]  modem_in,
  input  logic [NCH*MDM_W-1:0]  msr_delta,
  input  logic [NCH-1:0]        thr_wr,
  input  logic [NCH-1:0]        isr_rd,
  input  logic [SETTLE_W-1:0]   settle_cfg,
  output logic                  osc_en,
  output logic                  sleep_flag,
  output logic [NCH-1:0]        wake_irq
);
  import uslp_pkg::*;

  pwr_state_t state, state_nx;
  logic [NCH-1:0] qual, wake_evt, rx_s, rx_tog, mdm_tog;
  logic all_qual, any_wake, wake_fire, settle_done;

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      logic [MDM_W-1:0] mdm_s;

      uslp_pin_watch #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) rx_watch_i (
        .clk(clk), .rst(rst), .pins(rx_pin[c]),
        .pins_s(rx_s[c]), .toggled(rx_tog[c])
      );

      uslp_pin_watch #(.W(MDM_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) mdm_watch_i (
        .clk(clk), .rst(rst), .pins(modem_in[c*MDM_W +: MDM_W]),
        .pins_s(mdm_s), .toggled(mdm_tog[c])
      );

      uslp_chan_qual #(.DIV_W(DIV_W), .MDM_W(MDM_W)) qual_i (
        .sleep_en(sleep_en[c]), .irq_pend(irq_pend[c]),
        .txf_empty(txf_empty[c]), .rxf_empty(rxf_empty[c]),
        .rx_s(rx_s[c]), .ir_mode(ir_mode[c]),
        .divisor(divisor[c*DIV_W +: DIV_W]),
        .msr_delta(msr_delta[c*MDM_W +: MDM_W]),
        .thr_wr(thr_wr[c]), .pin_evt(rx_tog[c] | mdm_tog[c]),
        .wake_pend(wake_irq[c]),
        .qual(qual[c]), .wake_evt(wake_evt[c])
      );

      always_ff @(posedge clk) begin
        if (rst)            wake_irq[c] <= 1'b0;
        else if (wake_fire) wake_irq[c] <= 1'b1;
        else if (isr_rd[c]) wake_irq[c] <= 1'b0;
      end
    end
  endgenerate

  assign all_qual  = &qual;
  assign any_wake  = |wake_evt;
  assign wake_fire = (state == ST_SLEEP) && any_wake;

  uslp_settle #(.W(SETTLE_W)) settle_i (
    .clk(clk), .rst(rst), .load(wake_fire), .load_val(settle_cfg),
    .run(state == ST_SETTLE), .done(settle_done)
  );

  always_comb begin
    state_nx = state;
    case (state)
      ST_RUN:    if (all_qual)    state_nx = ST_SLEEP;
      ST_SLEEP:  if (any_wake)    state_nx = ST_SETTLE;
      ST_SETTLE: if (settle_done) state_nx = ST_RUN;
      default:                    state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_RUN;
      osc_en     <= 1'b1;
      sleep_flag <= 1'b0;
    end else begin
      state      <= state_nx;
      osc_en     <= (state_nx != ST_SLEEP);
      sleep_flag <= (state_nx != ST_RUN);
    end
  end
endmodule

// File: rtl/uart_sleep_ctrl_chk.sv
module uart_sleep_ctrl_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] sleep_en,
  input logic [NCH-1:0] irq_pend,
  input logic [NCH-1:0] txf_empty,
  input logic [NCH-1:0] rxf_empty,
  input logic [NCH-1:0] thr_wr,
  input logic [NCH-1:0] isr_rd,
  input logic           osc_en,
  input logic           sleep_flag,
  input logic [NCH-1:0] wake_irq
);
  p_entry_conds_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(osc_en) |-> $past(&sleep_en && !(|irq_pend) && &txf_empty && &rxf_empty && !(|thr_wr)));

  p_wake_on_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    (!osc_en && (|thr_wr)) |=> osc_en);

  p_wake_sets_irq_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(osc_en) |-> (&wake_irq));

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_irq
      p_irq_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (wake_irq[i] && !isr_rd[i]) |=> wake_irq[i]);
    end
  endgenerate

  p_asleep_flag_r8: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> sleep_flag);

  p_flag_drop_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep_flag) |-> $past(osc_en));

  p_no_irq_asleep_r9: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> (wake_irq == '0));
endmodule

bind uart_sleep_ctrl uart_sleep_ctrl_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst(rst), .sleep_en(sleep_en), .irq_pend(irq_pend),
  .txf_empty(txf_empty), .rxf_empty(rxf_empty), .thr_wr(thr_wr),
  .isr_rd(isr_rd), .osc_en(osc_en), .sleep_flag(sleep_flag),
  .wake_irq(wake_irq)
);

// File: tb/uart_sleep_ctrl_tb_top.sv
`timescale 1ns/1ps
module uart_sleep_ctrl_tb_top;
  localparam int NCH = 2;
  localparam int DIV_W = 16;
  localparam int MDM_W = 4;
  localparam int SETTLE_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] sleep_en, irq_pend, txf_empty, rxf_empty, rx_pin, ir_mode, thr_wr, isr_rd;
  logic [NCH*DIV_W-1:0] divisor;
  logic [NCH*MDM_W-1:0] modem_in, msr_delta;
  logic [SETTLE_W-1:0] settle_cfg;
  logic osc_en, sleep_flag;
  logic [NCH-1:0] wake_irq;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  uart_sleep_ctrl #(.NCH(NCH), .DIV_W(DIV_W), .MDM_W(MDM_W), .SETTLE_W(SETTLE_W)) dut_i (
    .clk(clk), .rst(rst), .sleep_en(sleep_en), .irq_pend(irq_pend),
    .txf_empty(txf_empty), .rxf_empty(rxf_empty), .rx_pin(rx_pin),
    .ir_mode(ir_mode), .divisor(divisor), .modem_in(modem_in),
    .msr_delta(msr_delta), .thr_wr(thr_wr), .isr_rd(isr_rd),
    .settle_cfg(settle_cfg), .osc_en(osc_en), .sleep_flag(sleep_flag),
    .wake_irq(wake_irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic e_osc, input logic e_flag, input logic [NCH-1:0] e_irq);
    check(osc_en === e_osc, {tag, " osc_en"}, 32'(osc_en), 32'(e_osc));
    check(sleep_flag === e_flag, {tag, " sleep_flag"}, 32'(sleep_flag), 32'(e_flag));
    check(wake_irq === e_irq, {tag, " wake_irq"}, 32'(wake_irq), 32'(e_irq));
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_irqs();
    isr_rd = '1;
    step();
    isr_rd = '0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Expected qualification of all channels, from R2 and R3 (rx levels held fixed).
  function automatic bit exp_qual(input logic [NCH-1:0] se, input logic [NCH-1:0] ip,
                                  input logic [NCH-1:0] te, input logic [NCH-1:0] re,
                                  input logic [NCH-1:0] rxl, input logic [NCH-1:0] irm,
                                  input logic [NCH*DIV_W-1:0] dv, input logic [NCH*MDM_W-1:0] md);
    bit q = 1'b1;
    for (int c = 0; c < NCH; c++) begin
      if (!se[c] || ip[c] || !te[c] || !re[c]) q = 1'b0;
      if (rxl[c] != !irm[c]) q = 1'b0;
      if (dv[c*DIV_W +: DIV_W] == '0) q = 1'b0;
      if (md[c*MDM_W +: MDM_W] != '0) q = 1'b0;
    end
    return q;
  endfunction

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        finish_run();
      end
    end
  end

  initial begin : stim
    void'($urandom(32'd4242));
    sleep_en = '0; irq_pend = '0; txf_empty = '1; rxf_empty = '1;
    rx_pin = '1; ir_mode = '0; thr_wr = '0; isr_rd = '0;
    divisor = {16'h0010, 16'h0003}; modem_in = '0; msr_delta = '0;
    settle_cfg = '0;
    @(negedge clk);
    repeat (3) step();
    chk_out("R1 in reset", 1'b1, 1'b0, '0);
    rst = 1'b0;
    step();
    chk_out("R1 after reset", 1'b1, 1'b0, '0);

    // R2: all channels qualify
    sleep_en = '1;
    step();
    chk_out("R2 entry", 1'b0, 1'b1, '0);

    // R10: non-wake changes while asleep
    divisor[15:0] = '0; txf_empty[1] = 1'b0; msr_delta[3:0] = 4'h2;
    repeat (3) step();
    chk_out("R10 stays asleep", 1'b0, 1'b1, '0);
    divisor[15:0] = 16'h0003; txf_empty[1] = 1'b1; msr_delta = '0;

    // R5 + R7 + R8: holding write wakes, settle of 2
    settle_cfg = 8'd2;
    thr_wr[1] = 1'b1;
    step();
    thr_wr = '0;
    chk_out("R5/R7 thr wake", 1'b1, 1'b1, 2'b11);
    step();
    check(sleep_flag === 1'b1, "R8 settle 1", 32'(sleep_flag), 1);
    step();
    check(sleep_flag === 1'b1, "R8 settle 2", 32'(sleep_flag), 1);
    step();
    check(sleep_flag === 1'b0, "R8 settle done", 32'(sleep_flag), 0);

    // R9: pending wake irq blocks re-entry; per-channel clear (R7)
    step();
    chk_out("R9 blocked by irq", 1'b1, 1'b0, 2'b11);
    isr_rd = 2'b01;
    step();
    chk_out("R7 clear ch0", 1'b1, 1'b0, 2'b10);
    isr_rd = 2'b10;
    step();
    chk_out("R7 clear ch1", 1'b1, 1'b0, 2'b00);
    isr_rd = '0;
    step();
    chk_out("R9 auto re-entry", 1'b0, 1'b1, '0);

    // R6: rx toggle wakes on third edge
    settle_cfg = 8'd0;
    rx_pin[0] = 1'b0;
    step();
    check(osc_en === 1'b0, "R6 rx edge+1", 32'(osc_en), 0);
    step();
    check(osc_en === 1'b0, "R6 rx edge+2", 32'(osc_en), 0);
    step();
    chk_out("R6 rx edge+3", 1'b1, 1'b1, 2'b11);
    step();
    check(sleep_flag === 1'b0, "R8 settle zero", 32'(sleep_flag), 0);
    clear_irqs();
    step(); step();
    check(osc_en === 1'b1, "R3 rx low not idle in normal mode", 32'(osc_en), 1);
    ir_mode[0] = 1'b1;
    step();
    check(osc_en === 1'b0, "R3 rx low idle in IR mode", 32'(osc_en), 0);

    // R6: modem toggle on channel 1
    modem_in[6] = 1'b1;
    step(); step();
    check(osc_en === 1'b0, "R6 modem edge+2", 32'(osc_en), 0);
    step();
    chk_out("R6 modem edge+3", 1'b1, 1'b1, 2'b11);
    step();
    clear_irqs();

    // R4: one channel blocks all
    msr_delta[7:4] = 4'b0001;
    step(); step();
    check(osc_en === 1'b1, "R4 ch1 blocks", 32'(osc_en), 1);
    msr_delta = '0;
    step();
    check(osc_en === 1'b0, "R4 released", 32'(osc_en), 0);

    // R5: interrupt pending wakes
    irq_pend[0] = 1'b1;
    step();
    chk_out("R5 irq wake", 1'b1, 1'b1, 2'b11);
    irq_pend = '0;
    step();
    clear_irqs();
    sleep_en = '0;
    step();
    check(osc_en === 1'b1, "R5 disabled stays awake", 32'(osc_en), 1);

    // Random phase: rx levels fixed (ch0 low in IR, ch1 high)
    for (int it = 0; it < 300; it++) begin
      logic [NCH-1:0] se, ip, te, re, irm;
      logic [NCH*DIV_W-1:0] dv;
      logic [NCH*MDM_W-1:0] md;
      bit e;
      for (int c = 0; c < NCH; c++) begin
        se[c]  = ($urandom % 8) != 0;
        ip[c]  = ($urandom % 8) == 0;
        te[c]  = ($urandom % 8) != 0;
        re[c]  = ($urandom % 8) != 0;
        irm[c] = (c == 0) ? (($urandom % 8) != 0) : (($urandom % 8) == 0);
        dv[c*DIV_W +: DIV_W] = (($urandom % 8) == 0) ? '0 : DIV_W'($urandom % 65535 + 1);
        md[c*MDM_W +: MDM_W] = (($urandom % 8) == 0) ? MDM_W'($urandom % 15 + 1) : '0;
      end
      sleep_en = se; irq_pend = ip; txf_empty = te; rxf_empty = re;
      ir_mode = irm; divisor = dv; msr_delta = md;
      e = exp_qual(se, ip, te, re, rx_pin, irm, dv, md);
      step();
      chk_out("R2/R4 random entry", !e, e, '0);
      if (e) begin
        settle_cfg = SETTLE_W'($urandom % 4);
        sleep_en = '0;
        step();
        chk_out("R5/R7 random wake", 1'b1, 1'b1, '1);
        for (int k = 0; k < int'(settle_cfg); k++) step();
        check(sleep_flag === 1'b1, "R8 random last settle", 32'(sleep_flag), 1);
        step();
        check(sleep_flag === 1'b0, "R8 random settle end", 32'(sleep_flag), 0);
        clear_irqs();
      end
    end
    finish_run();
  end
endmodule